// File: doc/BRIEF.md
# Branch Resolution and Return-Stack Unit

This block resolves the next program-counter value for every control-transfer opcode of an 8-bit processor with a 16-bit code address space. The fetch stage gives it the opcode, the up to three bytes that follow the opcode in code memory, the general registers A to G, one data-memory byte, the flag register and the current PC. From these it picks the next PC, raises a taken indication, and drives the strobes of a return stack.

The return stack is built as two separate byte-wide LIFOs, one for the high half of the saved address and one for the low half, which always move together. It is eight entries deep. A call that finds it full, or a return that finds it empty, raises an error flag, leaves the stored addresses untouched and lets execution fall through to the next byte. Compare-and-branch opcodes test register A for equality and jump directly, either to the address held in the F:G register pair (F is the high byte) or to a two-byte address placed in the instruction. Flag-test opcodes branch on one bit of the flag register.

All outputs are combinational functions of the inputs and of the stack state. The stack updates on the rising clock edge of a cycle in which `exec_en` is high.

Top module: `branch_unit`

## Requirements
- R1: After reset the return stack is empty, so the first return raises `underflow`.
- R2: Opcode 0x02 always jumps to {op_b1, op_b2} (high byte first), with `taken` high.
- R3: Opcode 0x04 always jumps to {reg_f, reg_g}, with `taken` high.
- R4: Opcode 0x05 with the stack not full pushes pc+1 (high byte to the upper stack, low byte to the lower stack) with `push_stb` high, and jumps to {reg_f, reg_g}.
- R5: Opcode 0x0C with the stack not empty pops with `pop_stb` high and jumps to the most recently pushed address. Addresses come back in last-in first-out order.
- R6: Opcodes 0xB0 to 0xB6 compare reg_a with the operand chosen by opcode[2:0] (0 = op_b1, 1 to 6 = reg_b to reg_g). If they are equal the opcode jumps to {reg_f, reg_g}. If not, next_pc is pc+2 for 0xB0 and pc+1 for the others.
- R7: Opcodes 0xC8 to 0xCF compare reg_a with the operand chosen by opcode[2:0] (0 = op_b1, 1 to 6 = reg_b to reg_g, 7 = mem_byte). If they are equal, 0xC8 jumps to {op_b2, op_b3} and the others jump to {op_b1, op_b2}. If not, next_pc is pc+4 for 0xC8 and pc+3 for the others.
- R8: Opcodes 0xC0 to 0xC7 jump to {op_b1, op_b2} when flags[opcode[2:0]] is 1, and go to pc+3 when it is 0.
- R9: A call with eight entries already stored raises `overflow`. It does not push, `taken` stays low, next_pc is pc+1, and the stored addresses stay unchanged.
- R10: A return with an empty stack raises `underflow`. It does not pop, `taken` stays low, and next_pc is pc+1.
- R11: With `exec_en` low, or with any opcode not listed above, `taken`, both strobes and both error flags stay low and next_pc is pc+1. With `exec_en` low the stack is also left unchanged.
- R12: All PC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | The opcode is executed this cycle |
| opcode | input | 8 | Current opcode |
| op_b1 | input | 8 | Code byte at pc+1 |
| op_b2 | input | 8 | Code byte at pc+2 |
| op_b3 | input | 8 | Code byte at pc+3 |
| reg_a | input | 8 | Register A |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_f | input | 8 | Register F, high byte of the pair target |
| reg_g | input | 8 | Register G, low byte of the pair target |
| mem_byte | input | 8 | Data-memory operand |
| flags | input | 8 | Flag register |
| pc | input | 16 | Address of the current opcode |
| next_pc | output | 16 | Resolved next PC |
| taken | output | 1 | A control transfer happens |
| push_stb | output | 1 | Return address pushed at the next edge |
| pop_stb | output | 1 | Return address popped at the next edge |
| overflow | output | 1 | Call refused because the stack is full |
| underflow | output | 1 | Return refused because the stack is empty |

## Verification
The bench fills the stack to exactly eight entries and then calls once more. A design that pushed anyway would corrupt the deepest entry, or miscount so that the eighth return failed, and the eight returns that follow would expose it. It sweeps every operand selector of both compare families with equal and unequal operands. Mixing up the inline-byte order of 0xC8 or its four-byte fall-through would give a wrong target or a PC off by one. It also runs the fall-through at pc = 0xFFFF, which catches a missed wrap, and issues calls with `exec_en` low. A design that still pushed in that case would return the wrong address later.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_JUMP_IMM,
    K_JUMP_PAIR,
    K_CALL,
    K_RET,
    K_CMP_PAIR,
    K_FLAG,
    K_CMP_INL
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [2:0] len;   // instruction length in bytes
    logic [2:0] sel;   // operand / flag selector
  } op_info_t;

  localparam logic [7:0] OP_JMP_IMM  = 8'h02;
  localparam logic [7:0] OP_JMP_PAIR = 8'h04;
  localparam logic [7:0] OP_CALL     = 8'h05;
  localparam logic [7:0] OP_RET      = 8'h0C;
  localparam logic [4:0] GRP_CMP_PAIR = 5'b10110;  // 0xB0..0xB7
  localparam logic [4:0] GRP_FLAG     = 5'b11000;  // 0xC0..0xC7
  localparam logic [4:0] GRP_CMP_INL  = 5'b11001;  // 0xC8..0xCF

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);

  logic [2:0] sel;
  logic [4:0] grp;

  assign sel = opcode[2:0];
  assign grp = opcode[7:3];

  always_comb begin
    info.kind = K_NONE;
    info.len  = 3'd1;
    info.sel  = sel;
    if (opcode == OP_JMP_IMM) begin
      info.kind = K_JUMP_IMM;
      info.len  = 3'd3;
    end else if (opcode == OP_JMP_PAIR) begin
      info.kind = K_JUMP_PAIR;
    end else if (opcode == OP_CALL) begin
      info.kind = K_CALL;
    end else if (opcode == OP_RET) begin
      info.kind = K_RET;
    end else if (grp == GRP_CMP_PAIR && sel != 3'd7) begin
      info.kind = K_CMP_PAIR;
      info.len  = (sel == 3'd0) ? 3'd2 : 3'd1;
    end else if (grp == GRP_FLAG) begin
      info.kind = K_FLAG;
      info.len  = 3'd3;
    end else if (grp == GRP_CMP_INL) begin
      info.kind = K_CMP_INL;
      info.len  = (sel == 3'd0) ? 3'd4 : 3'd3;
    end
  end

endmodule

// File: rtl/bru_compare.sv
module bru_compare #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [DATA_W-1:0] reg_c,
  input  logic [DATA_W-1:0] reg_d,
  input  logic [DATA_W-1:0] reg_e,
  input  logic [DATA_W-1:0] reg_f,
  input  logic [DATA_W-1:0] reg_g,
  input  logic [DATA_W-1:0] mem_byte,
  input  logic [7:0]        flags,
  output logic              equal,
  output logic              flag_hit
);

  logic [DATA_W-1:0] opnd [8];

  assign opnd[0] = imm;
  assign opnd[1] = reg_b;
  assign opnd[2] = reg_c;
  assign opnd[3] = reg_d;
  assign opnd[4] = reg_e;
  assign opnd[5] = reg_f;
  assign opnd[6] = reg_g;
  assign opnd[7] = mem_byte;

  assign equal    = (reg_a == opnd[sel]);
  assign flag_hit = flags[sel];

endmodule

// File: rtl/byte_stack.sv
module byte_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int CW = $clog2(DEPTH);
  localparam logic [CW:0] FULL_CNT = (CW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW:0]   cnt_q, cnt_d;
  logic          wr_en, rd_en;
  logic [CW-1:0] wr_idx, rd_idx;

  assign full   = (cnt_q == FULL_CNT);
  assign empty  = (cnt_q == '0);
  assign wr_en  = push && !full;
  assign rd_en  = pop && !empty;
  assign wr_idx = cnt_q[CW-1:0];
  assign rd_idx = CW'(cnt_q - 1'b1);
  assign dout   = empty ? '0 : mem[rd_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en && !rd_en)
      cnt_d = cnt_q + 1'b1;
    else if (rd_en && !wr_en)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_idx] <= din;
  end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import bru_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exec_en,
  input  logic [7:0]          opcode,
  input  logic [DATA_W-1:0]   op_b1,
  input  logic [DATA_W-1:0]   op_b2,
  input  logic [DATA_W-1:0]   op_b3,
  input  logic [DATA_W-1:0]   reg_a,
  input  logic [DATA_W-1:0]   reg_b,
  input  logic [DATA_W-1:0]   reg_c,
  input  logic [DATA_W-1:0]   reg_d,
  input  logic [DATA_W-1:0]   reg_e,
  input  logic [DATA_W-1:0]   reg_f,
  input  logic [DATA_W-1:0]   reg_g,
  input  logic [DATA_W-1:0]   mem_byte,
  input  logic [7:0]          flags,
  input  logic [2*DATA_W-1:0] pc,
  output logic [2*DATA_W-1:0] next_pc,
  output logic                taken,
  output logic                push_stb,
  output logic                pop_stb,
  output logic                overflow,
  output logic                underflow
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int HALVES = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  op_info_t          info;
  logic              equal, flag_hit;
  logic [ADDR_W-1:0] seq_pc, ret_addr, top_addr, pair_addr;
  logic [HALVES-1:0] full_v, empty_v;
  logic              stk_full, stk_empty;
  logic [DATA_W-1:0] half_top [HALVES];

  bru_decode u_dec (
    .opcode (opcode),
    .info   (info)
  );

  bru_compare #(.DATA_W(DATA_W)) u_cmp (
    .sel      (info.sel),
    .imm      (op_b1),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .reg_c    (reg_c),
    .reg_d    (reg_d),
    .reg_e    (reg_e),
    .reg_f    (reg_f),
    .reg_g    (reg_g),
    .mem_byte (mem_byte),
    .flags    (flags),
    .equal    (equal),
    .flag_hit (flag_hit)
  );

  // half 0 keeps the low byte, half 1 the high byte
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    byte_stack #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stk (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .push  (push_stb),
      .pop   (pop_stb),
      .din   (ret_addr[h*DATA_W +: DATA_W]),
      .dout  (half_top[h]),
      .full  (full_v[h]),
      .empty (empty_v[h])
    );
  end

  assign top_addr  = {half_top[1], half_top[0]};
  assign stk_full  = |full_v;
  assign stk_empty = |empty_v;
  assign pair_addr = {reg_f, reg_g};
  assign ret_addr  = pc + ADDR_W'(1);
  assign seq_pc    = pc + ADDR_W'(info.len);

  always_comb begin
    next_pc   = seq_pc;
    taken     = 1'b0;
    push_stb  = 1'b0;
    pop_stb   = 1'b0;
    overflow  = 1'b0;
    underflow = 1'b0;
    if (!exec_en) begin
      next_pc = ret_addr;
    end else begin
      unique case (info.kind)
        K_JUMP_IMM: begin
          taken   = 1'b1;
          next_pc = {op_b1, op_b2};
        end
        K_JUMP_PAIR: begin
          taken   = 1'b1;
          next_pc = pair_addr;
        end
        K_CALL: begin
          if (stk_full) begin
            overflow = 1'b1;
            next_pc  = ret_addr;
          end else begin
            push_stb = 1'b1;
            taken    = 1'b1;
            next_pc  = pair_addr;
          end
        end
        K_RET: begin
          if (stk_empty) begin
            underflow = 1'b1;
            next_pc   = ret_addr;
          end else begin
            pop_stb = 1'b1;
            taken   = 1'b1;
            next_pc = top_addr;
          end
        end
        K_CMP_PAIR: begin
          if (equal) begin
            taken   = 1'b1;
            next_pc = pair_addr;
          end
        end
        K_FLAG: begin
          if (flag_hit) begin
            taken   = 1'b1;
            next_pc = {op_b1, op_b2};
          end
        end
        K_CMP_INL: begin
          if (equal) begin
            taken   = 1'b1;
            next_pc = (info.sel == 3'd0) ? {op_b2, op_b3} : {op_b1, op_b2};
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                exec_en,
  input logic [7:0]          opcode,
  input logic [DATA_W-1:0]   op_b1,
  input logic [DATA_W-1:0]   op_b2,
  input logic [DATA_W-1:0]   reg_f,
  input logic [DATA_W-1:0]   reg_g,
  input logic [2*DATA_W-1:0] pc,
  input logic [2*DATA_W-1:0] next_pc,
  input logic                taken,
  input logic                push_stb,
  input logic                pop_stb,
  input logic                overflow,
  input logic                underflow
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int CW = $clog2(STACK_DEPTH);
  localparam logic [CW:0] FULL_CNT = (CW+1)'(STACK_DEPTH);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // occupancy counted from the strobes alone
  logic [CW:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      occ <= '0;
    else if (push_stb && !pop_stb)
      occ <= occ + 1'b1;
    else if (pop_stb && !push_stb)
      occ <= occ - 1'b1;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_stb |-> (occ < FULL_CNT));

  p_ovf_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (occ == FULL_CNT && !taken && !push_stb && next_pc == pc + ONE));

  p_unf_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (occ == '0 && !pop_stb && !taken && next_pc == pc + ONE));

  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_stb |-> (occ != '0 && taken));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> (!taken && !push_stb && !pop_stb && !overflow && !underflow
                  && next_pc == pc + ONE));

  p_jump_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'h02) |-> (taken && next_pc == {op_b1, op_b2}));

  p_jump_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'h04) |-> (taken && next_pc == {reg_f, reg_g}));

endmodule

bind branch_unit branch_unit_chk #(.DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (.*);

// File: tb/sim_branch_unit.sv
`timescale 1ns/1ps
module sim_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic [7:0]  opcode, op_b1, op_b2, op_b3;
  logic [7:0]  reg_a, reg_b, reg_c, reg_d, reg_e, reg_f, reg_g, mem_byte, flags;
  logic [15:0] pc;
  logic [15:0] next_pc;
  logic        taken, push_stb, pop_stb, overflow, underflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [15:0] model_q [$];

  always #2 clk = ~clk;  // 250 MHz

  branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .op_b1(op_b1), .op_b2(op_b2), .op_b3(op_b3),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
    .reg_e(reg_e), .reg_f(reg_f), .reg_g(reg_g), .mem_byte(mem_byte),
    .flags(flags), .pc(pc), .next_pc(next_pc), .taken(taken),
    .push_stb(push_stb), .pop_stb(pop_stb), .overflow(overflow),
    .underflow(underflow)
  );

  function automatic logic [7:0] pick(input logic [2:0] s);
    case (s)
      3'd0: return op_b1;
      3'd1: return reg_b;
      3'd2: return reg_c;
      3'd3: return reg_d;
      3'd4: return reg_e;
      3'd5: return reg_f;
      3'd6: return reg_g;
      default: return mem_byte;
    endcase
  endfunction

  // drive one opcode, compare all outputs against the model, then let the edge pass
  task automatic step(input string tag, input logic en, input logic [7:0] op,
                      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                      input logic [15:0] p);
    logic [15:0] e_pc;
    logic e_tk, e_pu, e_po, e_ov, e_un;
    @(negedge clk);
    exec_en = en; opcode = op; op_b1 = b1; op_b2 = b2; op_b3 = b3; pc = p;
    #1;
    e_pc = p + 16'd1; e_tk = 0; e_pu = 0; e_po = 0; e_ov = 0; e_un = 0;
    if (en) begin
      if (op == 8'h02) begin
        e_tk = 1; e_pc = {b1, b2};
      end else if (op == 8'h04) begin
        e_tk = 1; e_pc = {reg_f, reg_g};
      end else if (op == 8'h05) begin
        if (model_q.size() == 8) e_ov = 1;
        else begin e_pu = 1; e_tk = 1; e_pc = {reg_f, reg_g}; end
      end else if (op == 8'h0C) begin
        if (model_q.size() == 0) e_un = 1;
        else begin e_po = 1; e_tk = 1; e_pc = model_q[$]; end
      end else if (op >= 8'hB0 && op <= 8'hB6) begin
        if (reg_a == pick(op[2:0])) begin e_tk = 1; e_pc = {reg_f, reg_g}; end
        else e_pc = p + ((op == 8'hB0) ? 16'd2 : 16'd1);
      end else if (op >= 8'hC0 && op <= 8'hC7) begin
        if (flags[op[2:0]]) begin e_tk = 1; e_pc = {b1, b2}; end
        else e_pc = p + 16'd3;
      end else if (op >= 8'hC8 && op <= 8'hCF) begin
        if (reg_a == pick(op[2:0])) begin
          e_tk = 1; e_pc = (op == 8'hC8) ? {b2, b3} : {b1, b2};
        end else e_pc = p + ((op == 8'hC8) ? 16'd4 : 16'd3);
      end
    end
    n_checks++;
    if (next_pc !== e_pc || taken !== e_tk || push_stb !== e_pu || pop_stb !== e_po ||
        overflow !== e_ov || underflow !== e_un) begin
      n_fail++;
      $display("FAIL %s op=%02h: actual pc=%04h tk=%b pu=%b po=%b ov=%b un=%b expected pc=%04h tk=%b pu=%b po=%b ov=%b un=%b",
               tag, op, next_pc, taken, push_stb, pop_stb, overflow, underflow,
               e_pc, e_tk, e_pu, e_po, e_ov, e_un);
    end
    if (e_pu) model_q.push_back(p + 16'd1);
    if (e_po) void'(model_q.pop_back());
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; exec_en = 0; opcode = 0; op_b1 = 0; op_b2 = 0; op_b3 = 0;
    reg_a = 8'h11; reg_b = 8'h22; reg_c = 8'h33; reg_d = 8'h44; reg_e = 8'h55;
    reg_f = 8'h66; reg_g = 8'h77; mem_byte = 8'h88; flags = 8'h00; pc = 16'h0100;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    // R11 idle after reset, R1 first return underflows
    step("R11", 0, 8'h05, 0, 0, 0, 16'h0100);
    step("R1",  1, 8'h0C, 0, 0, 0, 16'h0200);
    step("R10", 1, 8'h0C, 0, 0, 0, 16'h0300);

    // R2, R3 unconditional jumps
    step("R2", 1, 8'h02, 8'h12, 8'h34, 8'h00, 16'h0400);
    step("R2", 1, 8'h02, 8'hFF, 8'h01, 8'h00, 16'h0410);
    step("R3", 1, 8'h04, 8'h00, 8'h00, 8'h00, 16'h0420);

    // R4, R5 calls and LIFO returns
    reg_f = 8'h10; reg_g = 8'h00;
    step("R4", 1, 8'h05, 0, 0, 0, 16'h1234);
    reg_f = 8'h20; reg_g = 8'h40;
    step("R4", 1, 8'h05, 0, 0, 0, 16'h20FF);
    step("R11", 0, 8'h05, 0, 0, 0, 16'h3333);
    step("R4", 1, 8'h05, 0, 0, 0, 16'hFFFF);
    step("R5", 1, 8'h0C, 0, 0, 0, 16'h5000);
    step("R5", 1, 8'h0C, 0, 0, 0, 16'h5001);
    step("R5", 1, 8'h0C, 0, 0, 0, 16'h5002);
    step("R10", 1, 8'h0C, 0, 0, 0, 16'h5003);

    // R9 fill to eight, then overflow, then drain
    for (int i = 0; i < 8; i++)
      step("R4", 1, 8'h05, 0, 0, 0, 16'h0A00 + 16'(i * 16'h0111));
    step("R9", 1, 8'h05, 0, 0, 0, 16'h7777);
    step("R9", 1, 8'h05, 0, 0, 0, 16'h8888);
    for (int i = 0; i < 8; i++)
      step("R9", 1, 8'h0C, 0, 0, 0, 16'h0900);
    step("R10", 1, 8'h0C, 0, 0, 0, 16'h0901);

    // R6 pair-target compares
    reg_a = 8'h5A; reg_b = 8'h01; reg_c = 8'h02; reg_d = 8'h03; reg_e = 8'h04;
    reg_f = 8'h05; reg_g = 8'h06; mem_byte = 8'h07;
    for (int k = 0; k < 7; k++) begin
      step("R6", 1, 8'hB0 + 8'(k), 8'h5B, 0, 0, 16'h0600);
      reg_a = pick(3'(k));
      if (k == 0) reg_a = 8'hC3;
      step("R6", 1, 8'hB0 + 8'(k), 8'hC3, 0, 0, 16'h0610);
      reg_a = 8'h5A;
    end
    step("R11", 1, 8'hB7, 8'h5A, 0, 0, 16'h0620);

    // R7 inline-target compares
    for (int k = 0; k < 8; k++) begin
      reg_a = 8'hE0;
      step("R7", 1, 8'hC8 + 8'(k), 8'hE1, 8'hAB, 8'hCD, 16'h0700);
      if (k == 0) reg_a = 8'hE1; else reg_a = pick(3'(k));
      step("R7", 1, 8'hC8 + 8'(k), 8'hE1, 8'hAB, 8'hCD, 16'h0710);
    end

    // R8 flag tests
    for (int k = 0; k < 8; k++) begin
      flags = 8'(1 << k);
      step("R8", 1, 8'hC0 + 8'(k), 8'h3C, 8'h4D, 0, 16'h0800);
      flags = ~8'(1 << k);
      step("R8", 1, 8'hC0 + 8'(k), 8'h3C, 8'h4D, 0, 16'h0810);
    end

    // R11 other opcodes, R12 wrap
    step("R11", 1, 8'h03, 8'h99, 8'h99, 0, 16'h0900);
    step("R11", 1, 8'h80, 0, 0, 0, 16'h0901);
    step("R12", 1, 8'h00, 0, 0, 0, 16'hFFFF);
    reg_a = 8'h00;
    step("R12", 1, 8'hC8, 8'h01, 0, 0, 16'hFFFE);
    flags = 8'h00;
    step("R12", 1, 8'hC3, 0, 0, 0, 16'hFFFE);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule